// File: doc/BRIEF.md
# SPI Memory Command Controller

This block is a register-programmed SPI master meant for serial flash devices. Software writes a transmit word and a command-control register; the controller then drives one of four chip selects, clocks out up to four command bytes and clocks in up to three reply bytes, all within one chip-select window. The bus works only in SPI mode 3: the clock rests high, data changes on the falling edge, and data is captured on the rising edge.

Two single-bit triggers start fixed flash commands with no transmit word to prepare. One reads the device status byte, which the controller places in its own status register. The other sends the write-enable command. A sticky completion flag in the status register tells software that the transfer has ended. Software clears the flag by writing zero to it. The two mode bits in the first control register are only stored for the memory-mapped paths that sit outside this block.

Top module: `smc_ctrl`

## Requirements
- R1: After reset every register reads zero, all chip selects are high, SCK is high and MOSI is low.
- R2: Control 1 (offset 0x00) stores bits 28 and 29 as read/write bits. Every other bit of it reads zero.
- R3: The bus uses mode 3 with a half period of H system clocks (parameter HALF_DIV). After chip select falls, SCK stays high for H cycles. Each bit is then H cycles low followed by H cycles high. MOSI changes only on a falling SCK edge, and MISO is captured on the rising edge.
- R4: Writing control 2 (offset 0x04) with bit 7 set starts a send. The transmit register (offset 0x0C) is sent with its low byte first and each byte MSB first, for the byte count in bits [2:0]. The receive bytes counted in bits [6:4] follow under the same chip select, while MOSI is held low. Chip select stays low for H*(2+16*(tx+rx)) cycles, starting in the cycle after the write.
- R5: After a send, the receive register (offset 0x10) holds the first received byte in [7:0], the second in [15:8] and the third in [23:16]. All bits not filled read zero. Only send transfers update this register.
- R6: Control 2 bits [13:12] = n pull only spi_cs_n[n] low. No more than one chip select is ever low.
- R7: Status (offset 0x08) bit 8 is the done flag. It sets on the edge where chip select returns high. A status write with bit 8 = 0 clears it. A write with bit 8 = 1 leaves it unchanged.
- R8: Control 2 bit 10 sends opcode 0x05, reads one byte and stores it in status bits [7:0]. That byte remains when the done flag is cleared.
- R9: Control 2 bit 11 sends the single opcode 0x06 and reads nothing.
- R10: When several trigger bits are written together, send wins over status read, and status read wins over write enable.
- R11: A control 2 write while a transfer or its following gap is in progress is ignored. Trigger bits always read back as zero.
- R12: A transmit count above 4 acts as 4 and a receive count above 3 acts as 3. Control 2 reads back the count fields exactly as written.
- R13: After chip select rises, a new transfer cannot start for 2H cycles. A trigger held from the rising cycle onward therefore sees chip select high for 2H+1 sampled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| spi_sck | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| spi_cs_n | output | 4 | Active-low chip selects, one per bank |

## Verification
The bench counts every result in cycles from the clock edge that accepts the control 2 write. Chip select is low at sampling point 1 and stays low through sampling point H*(2+16*bytes). The bench predicts SCK at each of those points from the same bit schedule. At the next sampling point, chip select is high and the done flag and the received data can be read. All samples are taken on the falling system-clock edge, one per cycle, with a running count of that position. The gap test keeps a trigger asserted from the rising cycle onward and expects exactly 2H+1 high samples before the next fall.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam logic [4:0] OFS_CR1 = 5'h00;
  localparam logic [4:0] OFS_CR2 = 5'h04;
  localparam logic [4:0] OFS_SR  = 5'h08;
  localparam logic [4:0] OFS_TX  = 5'h0C;
  localparam logic [4:0] OFS_RX  = 5'h10;

  localparam int MODE_A_BIT = 28;
  localparam int MODE_B_BIT = 29;
  localparam int GO_SEND    = 7;
  localparam int GO_STAT    = 10;
  localparam int GO_WREN    = 11;
  localparam int DONE_BIT   = 8;

  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WRENA  = 8'h06;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LEAD, PH_LOW, PH_HIGH, PH_TRAIL, PH_GAP1, PH_GAP2
  } phase_e;

  typedef enum logic [1:0] {K_SEND, K_STAT, K_WREN} kind_e;
endpackage

// File: rtl/smc_tick.sv
module smc_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smc_engine.sv
module smc_engine import smc_pkg::*; #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] tx_word,
  input  logic [2:0]  tx_cnt,
  input  logic [1:0]  rx_cnt,
  input  logic [1:0]  bank,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic [23:0] rx_word,
  output logic        sck,
  output logic        mosi,
  output logic [3:0]  cs_n
);
  phase_e      st_q, st_d;
  logic [5:0]  idx_q, idx_d, txb_q, txb_d, nb_q, nb_d, rpos;
  logic [31:0] txw_q, txw_d;
  logic [23:0] rxw_q, rxw_d;
  logic        sck_q, sck_d, mosi_q, mosi_d;
  logic [3:0]  csn_q, csn_d;
  logic        tick;

  function automatic logic pick_bit(input logic [31:0] w, input logic [5:0] i,
                                    input logic [5:0] lim);
    return (i < lim) ? w[{i[4:3], ~i[2:0]}] : 1'b0;
  endfunction

  smc_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
  );

  assign busy    = (st_q != PH_IDLE);
  assign done    = (st_q == PH_TRAIL) && tick;
  assign rx_word = rxw_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign cs_n    = csn_q;
  assign rpos    = idx_q - txb_q;

  always_comb begin
    st_d = st_q;  idx_d = idx_q;  txb_d = txb_q;  nb_d = nb_q;
    txw_d = txw_q; rxw_d = rxw_q; sck_d = sck_q;  mosi_d = mosi_q;
    csn_d = csn_q;
    unique case (st_q)
      PH_IDLE: if (start) begin
        st_d  = PH_LEAD;
        csn_d = ~(4'b0001 << bank);
        txw_d = tx_word;
        txb_d = {tx_cnt, 3'b000};
        nb_d  = {tx_cnt, 3'b000} + 6'({rx_cnt, 3'b000});
        idx_d = '0;
        rxw_d = '0;
      end
      PH_LEAD: if (tick) begin
        if (nb_q == '0) st_d = PH_TRAIL;
        else begin
          st_d   = PH_LOW;
          sck_d  = 1'b0;
          mosi_d = pick_bit(txw_q, idx_q, txb_q);
        end
      end
      PH_LOW: if (tick) begin
        st_d  = PH_HIGH;
        sck_d = 1'b1;
        if (idx_q >= txb_q) rxw_d[{rpos[4:3], ~rpos[2:0]}] = miso;
      end
      PH_HIGH: if (tick) begin
        if (idx_q == nb_q - 6'd1) st_d = PH_TRAIL;
        else begin
          idx_d  = idx_q + 6'd1;
          st_d   = PH_LOW;
          sck_d  = 1'b0;
          mosi_d = pick_bit(txw_q, idx_q + 6'd1, txb_q);
        end
      end
      PH_TRAIL: if (tick) begin
        st_d   = PH_GAP1;
        csn_d  = 4'hF;
        mosi_d = 1'b0;
      end
      PH_GAP1: if (tick) st_d = PH_GAP2;
      PH_GAP2: if (tick) st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE; idx_q <= '0; txb_q <= '0; nb_q <= '0;
      txw_q <= '0; rxw_q <= '0; sck_q <= 1'b1; mosi_q <= 1'b0; csn_q <= 4'hF;
    end else begin
      st_q <= st_d; idx_q <= idx_d; txb_q <= txb_d; nb_q <= nb_d;
      txw_q <= txw_d; rxw_q <= rxw_d; sck_q <= sck_d; mosi_q <= mosi_d; csn_q <= csn_d;
    end
  end
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl import smc_pkg::*; #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [3:0]  spi_cs_n
);
  logic [1:0]  rs_q;
  logic        rst_s;
  logic        wr_c1, wr_c2, wr_sr, wr_tx, start, busy, done;
  logic [31:0] e_word;
  logic [2:0]  e_tx;
  logic [1:0]  e_rx;
  kind_e       e_kind, kind_q, kind_d;
  logic [23:0] e_rxw;
  logic [1:0]  mode_q, mode_d, bank_q, bank_d;
  logic [2:0]  txf_q, txf_d, rxf_q, rxf_d;
  logic [31:0] tx_q, tx_d, rxd_q, rxd_d, cr2_rd;
  logic [7:0]  fst_q, fst_d;
  logic        fin_q, fin_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  smc_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_s), .start(start), .tx_word(e_word), .tx_cnt(e_tx),
    .rx_cnt(e_rx), .bank(reg_wdata[13:12]), .miso(spi_miso), .busy(busy),
    .done(done), .rx_word(e_rxw), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );

  always_comb begin
    wr_c1 = reg_wr && (reg_addr == OFS_CR1);
    wr_c2 = reg_wr && (reg_addr == OFS_CR2);
    wr_sr = reg_wr && (reg_addr == OFS_SR);
    wr_tx = reg_wr && (reg_addr == OFS_TX);
    start = wr_c2 && !busy &&
            (reg_wdata[GO_SEND] || reg_wdata[GO_STAT] || reg_wdata[GO_WREN]);
    if (reg_wdata[GO_SEND]) begin
      e_word = tx_q;
      e_tx   = (reg_wdata[2:0] > 3'd4) ? 3'd4 : reg_wdata[2:0];
      e_rx   = (reg_wdata[6:4] > 3'd3) ? 2'd3 : reg_wdata[5:4];
      e_kind = K_SEND;
    end else if (reg_wdata[GO_STAT]) begin
      e_word = {24'd0, OP_STATUS}; e_tx = 3'd1; e_rx = 2'd1; e_kind = K_STAT;
    end else begin
      e_word = {24'd0, OP_WRENA};  e_tx = 3'd1; e_rx = 2'd0; e_kind = K_WREN;
    end
  end

  always_comb begin
    mode_d = wr_c1 ? {reg_wdata[MODE_B_BIT], reg_wdata[MODE_A_BIT]} : mode_q;
    txf_d  = (wr_c2 && !busy) ? reg_wdata[2:0]   : txf_q;
    rxf_d  = (wr_c2 && !busy) ? reg_wdata[6:4]   : rxf_q;
    bank_d = (wr_c2 && !busy) ? reg_wdata[13:12] : bank_q;
    tx_d   = wr_tx ? reg_wdata : tx_q;
    kind_d = start ? e_kind : kind_q;
    rxd_d  = (done && kind_q == K_SEND) ? {8'd0, e_rxw} : rxd_q;
    fst_d  = (done && kind_q == K_STAT) ? e_rxw[7:0]    : fst_q;
    if (done)                             fin_d = 1'b1;
    else if (wr_sr && !reg_wdata[DONE_BIT]) fin_d = 1'b0;
    else                                  fin_d = fin_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mode_q <= '0; txf_q <= '0; rxf_q <= '0; bank_q <= '0; tx_q <= '0;
      kind_q <= K_SEND; rxd_q <= '0; fst_q <= '0; fin_q <= 1'b0;
    end else begin
      mode_q <= mode_d; txf_q <= txf_d; rxf_q <= rxf_d; bank_q <= bank_d; tx_q <= tx_d;
      kind_q <= kind_d; rxd_q <= rxd_d; fst_q <= fst_d; fin_q <= fin_d;
    end
  end

  assign cr2_rd = {18'd0, bank_q, 5'd0, rxf_q, 1'b0, txf_q};

  always_comb begin
    unique case (reg_addr)
      OFS_CR1: reg_rdata = {2'b00, mode_q, 28'd0};
      OFS_CR2: reg_rdata = cr2_rd;
      OFS_SR:  reg_rdata = {23'd0, fin_q, fst_q};
      OFS_TX:  reg_rdata = tx_q;
      OFS_RX:  reg_rdata = rxd_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/smc_ctrl_chk.sv
module smc_ctrl_chk #(
  parameter int HALF_DIV = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        spi_sck,
  input logic        spi_mosi,
  input logic [3:0]  spi_cs_n,
  input logic        fin,
  input logic        busy,
  input logic [31:0] cr2_view
);
  localparam int GAPMIN = 2 * HALF_DIV;
  logic [15:0] gap_cnt;
  logic        idle_bus;

  assign idle_bus = &spi_cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gap_cnt <= 16'(GAPMIN);
    else if (!idle_bus)                  gap_cnt <= '0;
    else if (gap_cnt < 16'(GAPMIN))      gap_cnt <= gap_cnt + 16'd1;
  end

  // R3
  sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_bus |-> spi_sck);
  // R3
  mosi_falling_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_bus && !$fell(spi_sck)) |-> $stable(spi_mosi));
  // R6
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !(reg_wr && reg_addr == 5'h08 && !reg_wdata[8])) |=> fin);
  // R11
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 5'h04) |=> $stable(cr2_view));
  // R13
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_bus && $past(idle_bus)) |-> (gap_cnt >= 16'(GAPMIN)));
endmodule

bind smc_ctrl smc_ctrl_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .fin(fin_q), .busy(busy), .cr2_view(cr2_rd)
);

// File: tb/sim_smc_ctrl.sv
`timescale 1ns/100ps
module sim_smc_ctrl;
  localparam int HD = 2;
  localparam logic [4:0] A_C1 = 5'h00, A_C2 = 5'h04, A_SR = 5'h08, A_TX = 5'h0C, A_RX = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, spi_miso = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        spi_sck, spi_mosi;
  logic [3:0]  spi_cs_n;
  int n_run = 0, n_fail = 0, sck_falls = 0;
  bit finished = 1'b0;
  bit out_bits[$];
  bit resp_bits[$];

  smc_ctrl #(.HALF_DIV(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #2.5 clk = ~clk;

  // behavioural memory device: drives on falling SCK, captures on rising SCK
  always @(negedge spi_sck) if (!(&spi_cs_n)) begin
    sck_falls++;
    if (resp_bits.size() > 0) spi_miso = resp_bits.pop_front();
    else                      spi_miso = 1'b1;
  end
  always @(posedge spi_sck) if (!(&spi_cs_n)) out_bits.push_back(spi_mosi);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic load_resp(input int dummy, input logic [31:0] w, input int n);
    resp_bits.delete();
    for (int i = 0; i < dummy * 8; i++) resp_bits.push_back(1'b1);
    for (int b = 0; b < n; b++)
      for (int j = 7; j >= 0; j--) resp_bits.push_back(w[b*8+j]);
  endtask

  function automatic logic [7:0] out_byte(input int k);
    logic [7:0] r = '0;
    for (int j = 0; j < 8; j++)
      if (k*8 + j < out_bits.size()) r[7-j] = out_bits[k*8+j];
    return r;
  endfunction

  // reference timing model: expected CS and SCK at every sampled cycle
  task automatic xfer(input string tag, input logic [31:0] cr2, input int nbytes,
                      input logic [3:0] exp_cs);
    int len = HD * (2 + 16 * nbytes);
    int bad_cs = 0, bad_sck = 0;
    out_bits.delete(); sck_falls = 0;
    wr(A_C2, cr2);
    for (int k = 1; k <= len; k++) begin
      logic exp_sck = 1'b1;
      @(negedge clk);
      if (k > HD) begin
        int m = k - HD - 1;
        if ((m / (2*HD)) < nbytes * 8 && (m % (2*HD)) < HD) exp_sck = 1'b0;
      end
      if (spi_cs_n !== exp_cs)  bad_cs++;
      if (spi_sck  !== exp_sck) bad_sck++;
    end
    chk({tag, " R4 R6 cs window mismatches"}, 32'(bad_cs), 32'd0);
    chk({tag, " R3 sck waveform mismatches"}, 32'(bad_sck), 32'd0);
    @(negedge clk);
    chk({tag, " R6 cs released"}, {28'd0, spi_cs_n}, 32'h0000000F);
    reg_addr = A_SR; #1;
    chk({tag, " R7 done flag set"}, {31'd0, reg_rdata[8]}, 32'd1);
    chk({tag, " R3 sck falls"}, 32'(sck_falls), 32'(nbytes * 8));
    repeat (2*HD + 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1-scope run hung actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_C1, v); chk("R1 ctrl1 reset", v, 32'd0);
    rd(A_C2, v); chk("R1 ctrl2 reset", v, 32'd0);
    rd(A_SR, v); chk("R1 status reset", v, 32'd0);
    rd(A_TX, v); chk("R1 tx reset", v, 32'd0);
    rd(A_RX, v); chk("R1 rx reset", v, 32'd0);
    chk("R1 pins reset", {29'd0, spi_cs_n == 4'hF, spi_sck, spi_mosi}, 32'b110);

    // R2 mode bits
    wr(A_C1, 32'hFFFF_FFFF); rd(A_C1, v); chk("R2 mode bits only", v, 32'h3000_0000);
    wr(A_C1, 32'h1000_0000); rd(A_C1, v); chk("R2 single mode bit", v, 32'h1000_0000);

    // R4 R5 identification style: 1 tx, 3 rx, bank 2
    wr(A_TX, 32'h0000_009F);
    load_resp(1, 32'h0017_20C2, 3);
    xfer("id", 32'h0000_20B1, 4, 4'b1011);
    chk("R4 id opcode on MOSI", {24'd0, out_byte(0)}, 32'h9F);
    chk("R4 MOSI low during receive", {8'd0, out_byte(3), out_byte(2), out_byte(1)}, 32'd0);
    rd(A_RX, v); chk("R5 receive packing", v, 32'h0017_20C2);
    rd(A_C2, v); chk("R11 trigger self-clears", v, 32'h0000_2031);
    wr(A_SR, 32'h0000_0100); rd(A_SR, v); chk("R7 write one keeps flag", {31'd0, v[8]}, 32'd1);
    wr(A_SR, 32'h0000_0000); rd(A_SR, v); chk("R7 write zero clears flag", {31'd0, v[8]}, 32'd0);

    // R4 low byte first, four bytes, no receive
    wr(A_TX, 32'h4433_2211);
    load_resp(4, 32'd0, 0);
    xfer("tx4", 32'h0000_0084, 4, 4'b1110);
    chk("R4 byte order", {out_byte(3), out_byte(2), out_byte(1), out_byte(0)}, 32'h4433_2211);
    rd(A_RX, v); chk("R5 no receive bytes gives zero", v, 32'd0);
    wr(A_SR, 32'd0);

    // R8 status read on bank 1
    load_resp(1, 32'h0000_005A, 1);
    xfer("stat", 32'h0000_1400, 2, 4'b1101);
    chk("R8 status opcode", {24'd0, out_byte(0)}, 32'h05);
    rd(A_SR, v); chk("R8 status byte and flag", v, 32'h0000_015A);
    rd(A_RX, v); chk("R5 status read leaves receive reg", v, 32'd0);
    wr(A_SR, 32'd0); rd(A_SR, v); chk("R8 byte kept after flag clear", v, 32'h0000_005A);

    // R9 write enable on bank 3
    load_resp(0, 32'd0, 0);
    xfer("wren", 32'h0000_3800, 1, 4'b0111);
    chk("R9 write-enable opcode", {24'd0, out_byte(0)}, 32'h06);
    chk("R9 single byte", 32'(out_bits.size()), 32'd8);
    wr(A_SR, 32'd0);

    // R10 priority: all three triggers, send must win
    wr(A_TX, 32'h0000_00AB);
    load_resp(1, 32'd0, 0);
    xfer("prio", 32'h0000_0C81, 1, 4'b1110);
    chk("R10 send wins", {24'd0, out_byte(0)}, 32'hAB);
    rd(A_SR, v); chk("R10 status read not run", v, 32'h0000_015A);
    wr(A_SR, 32'd0);

    // R12 count clamping
    wr(A_TX, 32'h0D0C_0B0A);
    load_resp(4, 32'h0033_2211, 3);
    xfer("clamp", 32'h0000_00F7, 7, 4'b1110);
    chk("R12 tx clamped to four", {out_byte(3), out_byte(2), out_byte(1), out_byte(0)}, 32'h0D0C_0B0A);
    rd(A_RX, v); chk("R12 rx clamped to three", v, 32'h0033_2211);
    rd(A_C2, v); chk("R12 raw count fields", v, 32'h0000_0077);
    wr(A_SR, 32'd0);

    // R11 write during transfer ignored, then R13 gap
    wr(A_TX, 32'h0000_005C);
    load_resp(1, 32'd0, 0);
    out_bits.delete();
    begin
      int len = HD * (2 + 16);
      int bad = 0;
      wr(A_C2, 32'h0000_1081);
      wr(A_C2, 32'h0000_3084);
      for (int k = 2; k <= len; k++) begin
        @(negedge clk);
        if (spi_cs_n !== 4'b1101) bad++;
      end
      chk("R11 busy write left cs window", 32'(bad), 32'd0);
      @(negedge clk);
      chk("R11 single byte sent", {24'd0, out_byte(0)}, 32'h5C);
      reg_addr = A_C2; #1;
      chk("R11 ctrl2 unchanged", reg_rdata, 32'h0000_1001);
      reg_wr = 1'b1; reg_wdata = 32'h0000_2081;
      hi = 1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (&spi_cs_n) hi++;
        else break;
      end
      reg_wr = 1'b0;
      chk("R13 cs high gap", 32'(hi), 32'(2*HD + 1));
      chk("R13 next bank selected", {28'd0, spi_cs_n}, 32'h0000000B);
      repeat (HD * 20 + 4*HD) @(negedge clk);
      chk("R13 second transfer finished", {28'd0, spi_cs_n}, 32'h0000000F);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule